// File: doc/BRIEF.md
# Indexed Address Generation Sequencer

This block forms the effective address of an absolute indexed read on a byte-wide data bus. After the opcode has been fetched, a start pulse gives it a pointer to the operand and an index byte. It then reads the two operand bytes, low byte first, from consecutive addresses. The low operand byte is added to the index while the high byte is on the bus. When the high byte arrives, the block reads at once from the high byte joined to the low sum, without waiting to see whether that sum carried.

If the low sum did not carry, that first read is the answer. The block returns the byte with a one-cycle done pulse three cycles after start. If the sum did carry, the first read is thrown away. One more cycle reads the address one page (2^DW bytes) higher, so done comes four cycles after start. Latency therefore depends on the data. The read memory is expected to present rd_data in the same cycle that rd_addr and rd_en are shown.

Top module: `agu_indexed_read`

## Requirements
- R1: A synchronous active-high reset, applied at any time, leaves rd_en and done low in the following cycle and returns the block to idle.
- R2: In the first cycle after an accepted start, rd_en is high and rd_addr equals the operand pointer; in the second cycle rd_en is high and rd_addr equals the pointer plus one.
- R3: In the third cycle after start, rd_en is high and rd_addr equals the high operand byte in bits 15:8 and (low operand byte + index) mod 256 in bits 7:0.
- R4: When the low byte plus index is below 256, done is high for the fourth cycle after start (three cycles of latency), data_out equals the byte read in the third cycle, and rd_en is low.
- R5: When the low byte plus index is 256 or more, the third-cycle read is discarded: done stays low in it. In the fourth cycle rd_en is high and rd_addr is the third-cycle address plus 256. Done with data_out equal to that byte follows in the fifth cycle (four cycles of latency).
- R6: The page correction wraps modulo 2^16, so a carry with high byte 0xFF reads at 0x00xx.
- R7: A start pulse that arrives while a read sequence is in progress is ignored and does not change the sequence's addresses or result.
- R8: done is a single-cycle pulse, and rd_en is low in every cycle in which the block is idle.
- R9: The second operand fetch wraps modulo 2^16, so a pointer of 0xFFFF fetches the high byte from 0x0000.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle request to begin an indexed read |
| oper_ptr | input | 2*DW | Address of the low operand byte, sampled with start |
| index | input | DW | Index value, sampled with start |
| rd_data | input | DW | Byte returned by memory for the current rd_addr |
| rd_addr | output | 2*DW | Registered bus address |
| rd_en | output | 1 | Registered read strobe |
| data_out | output | DW | Fetched data byte, valid while done is high |
| done | output | 1 | One-cycle completion pulse |

## Verification
The bench builds the block with DW = 8, which gives a 16-bit address space of 256-byte pages. At that size, single operands reach both the no-carry and carry latencies and the exact boundaries of the low add (0xFF + 0x01, 0x00 + 0xFF). They also reach the wrap of the page correction past 0xFFxx and the operand fetch that wraps from 0xFFFF to 0x0000. A behavioural model compares rd_en, rd_addr, done and data_out every cycle. The runs include a start during a busy sequence and a reset in the middle of one.

// File: rtl/agu_pkg.sv
package agu_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LO,
    ST_HI,
    ST_SPEC,
    ST_FIX
  } agu_state_t;
endpackage

// File: rtl/agu_low_add.sv
// Low-byte adder: operand low byte plus index, with carry out.
module agu_low_add #(
  parameter int W = 8
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] sum,
  output logic         carry
);
  logic [W:0] wide;
  always_comb begin
    wide  = {1'b0, a} + {1'b0, b};
    sum   = wide[W-1:0];
    carry = wide[W];
  end
endmodule

// File: rtl/agu_page_step.sv
// Adds one page to an address; only the upper part changes, wrapping at the top.
module agu_page_step #(
  parameter int AW = 16,
  parameter int PW = 8
) (
  input  logic [AW-1:0] addr_in,
  output logic [AW-1:0] addr_out
);
  localparam int HW = AW - PW;
  logic [HW-1:0] upper;
  always_comb begin
    upper    = addr_in[AW-1:PW] + HW'(1);
    addr_out = {upper, addr_in[PW-1:0]};
  end
endmodule

// File: rtl/agu_indexed_read.sv
module agu_indexed_read
  import agu_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            start,
  input  logic [2*DW-1:0] oper_ptr,
  input  logic [DW-1:0]   index,
  input  logic [DW-1:0]   rd_data,
  output logic [2*DW-1:0] rd_addr,
  output logic            rd_en,
  output logic [DW-1:0]   data_out,
  output logic            done
);
  localparam int AW = 2 * DW;

  agu_state_t    state_q;
  logic [AW-1:0] addr_q;
  logic          en_q;
  logic [DW-1:0] lo_q;
  logic [DW-1:0] idx_q;
  logic          carry_q;
  logic [DW-1:0] data_q;
  logic          done_q;

  logic [DW-1:0] lo_sum;
  logic          lo_carry;
  logic [AW-1:0] paged_addr;

  // Low add runs during the high-byte fetch cycle
  agu_low_add #(.W(DW)) u_low_add (
    .a     (lo_q),
    .b     (idx_q),
    .sum   (lo_sum),
    .carry (lo_carry)
  );

  agu_page_step #(.AW(AW), .PW(DW)) u_page_step (
    .addr_in  (addr_q),
    .addr_out (paged_addr)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      addr_q  <= '0;
      en_q    <= 1'b0;
      lo_q    <= '0;
      idx_q   <= '0;
      carry_q <= 1'b0;
      data_q  <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (start) begin
            addr_q  <= oper_ptr;
            en_q    <= 1'b1;
            idx_q   <= index;
            state_q <= ST_LO;
          end
        end
        ST_LO: begin
          lo_q    <= rd_data;
          addr_q  <= addr_q + AW'(1);
          state_q <= ST_HI;
        end
        ST_HI: begin
          // speculative address: high byte taken as is
          addr_q  <= {rd_data, lo_sum};
          carry_q <= lo_carry;
          state_q <= ST_SPEC;
        end
        ST_SPEC: begin
          if (carry_q) begin
            addr_q  <= paged_addr;
            state_q <= ST_FIX;
          end else begin
            data_q  <= rd_data;
            done_q  <= 1'b1;
            en_q    <= 1'b0;
            state_q <= ST_IDLE;
          end
        end
        ST_FIX: begin
          data_q  <= rd_data;
          done_q  <= 1'b1;
          en_q    <= 1'b0;
          state_q <= ST_IDLE;
        end
        default: begin
          en_q    <= 1'b0;
          state_q <= ST_IDLE;
        end
      endcase
    end
  end

  assign rd_addr  = addr_q;
  assign rd_en    = en_q;
  assign data_out = data_q;
  assign done     = done_q;
endmodule

// File: rtl/agu_indexed_read_chk.sv
module agu_indexed_read_chk #(
  parameter int DW = 8
) (
  input logic            clk,
  input logic            rst,
  input logic            rd_en,
  input logic [2*DW-1:0] rd_addr,
  input logic            done
);
  localparam int AW = 2 * DW;
  localparam logic [AW-1:0] PAGE = AW'(1) << DW;

  logic       rst_d;
  logic [2:0] run_cnt;

  always_ff @(posedge clk) begin
    rst_d <= rst;
    if (rst)        run_cnt <= '0;
    else if (rd_en) run_cnt <= run_cnt + 3'd1;
    else            run_cnt <= '0;
  end

  // R1
  reset_idle_chk: assert property (@(posedge clk) disable iff (rst)
    rst_d |-> (!rd_en && !done));

  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R4
  done_strobe_low_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> !rd_en);

  // R2
  second_fetch_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_en && run_cnt == 3'd1) |-> (rd_addr == $past(rd_addr) + AW'(1)));

  // R5
  fix_addr_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_en && run_cnt == 3'd3) |-> (rd_addr == $past(rd_addr) + PAGE));

  // R5
  spec_no_done_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_en && run_cnt == 3'd3) |-> !$past(done));

  // R4
  run_length_chk: assert property (@(posedge clk) disable iff (rst)
    rd_en |-> (run_cnt < 3'd4));
endmodule

bind agu_indexed_read agu_indexed_read_chk #(.DW(DW)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .rd_en   (rd_en),
  .rd_addr (rd_addr),
  .done    (done)
);

// File: tb/agu_indexed_read_bench.sv
module agu_indexed_read_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [15:0] oper_ptr = '0;
  logic [7:0]  index = '0;
  logic [7:0]  rd_data;
  logic [15:0] rd_addr;
  logic        rd_en;
  logic [7:0]  data_out;
  logic        done;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;

  logic [15:0] op_pc  = 16'h0000;
  logic [7:0]  op_lo  = 8'h00;
  logic [7:0]  op_hi  = 8'h00;

  always #10 clk = ~clk;

  agu_indexed_read #(.DW(8)) u_agu_indexed_read (
    .clk      (clk),
    .rst      (rst),
    .start    (start),
    .oper_ptr (oper_ptr),
    .index    (index),
    .rd_data  (rd_data),
    .rd_addr  (rd_addr),
    .rd_en    (rd_en),
    .data_out (data_out),
    .done     (done)
  );

  function automatic logic [7:0] mem_byte(input logic [15:0] a);
    if (a == op_pc)                 return op_lo;
    else if (a == op_pc + 16'd1)    return op_hi;
    else                            return a[7:0] ^ (a[15:8] * 8'h3b) ^ 8'h5a;
  endfunction

  assign rd_data = mem_byte(rd_addr);

  task automatic chk(input string req, input string what,
                     input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic cyc(input string req, input logic e_en, input logic [15:0] e_addr,
                     input logic e_done, input logic [7:0] e_data, input logic chk_data);
    chk(req, "rd_en", {15'd0, rd_en}, {15'd0, e_en});
    if (e_en) chk(req, "rd_addr", rd_addr, e_addr);
    chk(req, "done", {15'd0, done}, {15'd0, e_done});
    if (chk_data) chk(req, "data_out", {8'd0, data_out}, {8'd0, e_data});
  endtask

  // Reference model: one indexed read, checked every cycle
  task automatic run_op(input string req, input logic [15:0] pc, input logic [7:0] lo,
                        input logic [7:0] hi, input logic [7:0] idx, input logic busy_start);
    int          sum;
    logic [15:0] spec;
    logic [15:0] fix;
    op_pc = pc; op_lo = lo; op_hi = hi;
    sum  = int'(lo) + int'(idx);
    spec = {hi, 8'(sum)};
    fix  = spec + 16'h0100;
    @(negedge clk);
    start = 1'b1; oper_ptr = pc; index = idx;
    @(negedge clk);
    start = busy_start; oper_ptr = 16'h5555; index = 8'hAA;
    cyc({req, " R2 lo fetch"}, 1'b1, pc, 1'b0, 8'h00, 1'b0);
    @(negedge clk);
    start = 1'b0;
    cyc({req, " R2/R9 hi fetch"}, 1'b1, pc + 16'd1, 1'b0, 8'h00, 1'b0);
    @(negedge clk);
    cyc({req, " R3 speculative read"}, 1'b1, spec, 1'b0, 8'h00, 1'b0);
    if (sum < 256) begin
      @(negedge clk);
      cyc({req, " R4 done after 3"}, 1'b0, 16'h0000, 1'b1, mem_byte(spec), 1'b1);
    end else begin
      @(negedge clk);
      cyc({req, " R5/R6 fix-up read"}, 1'b1, fix, 1'b0, 8'h00, 1'b0);
      @(negedge clk);
      cyc({req, " R5 done after 4"}, 1'b0, 16'h0000, 1'b1, mem_byte(fix), 1'b1);
    end
    @(negedge clk);
    cyc({req, " R8 pulse ends"}, 1'b0, 16'h0000, 1'b0, 8'h00, 1'b0);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 100000) begin
        fails++; checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    cyc("R1 reset state", 1'b0, 16'h0000, 1'b0, 8'h00, 1'b1);
    @(negedge clk);
    cyc("R8 idle", 1'b0, 16'h0000, 1'b0, 8'h00, 1'b0);

    run_op("no cross",     16'h1230, 8'h10, 8'h40, 8'h05, 1'b0);
    run_op("cross",        16'h2000, 8'hF0, 8'h40, 8'h20, 1'b0);
    run_op("edge carry",   16'h3000, 8'hFF, 8'h12, 8'h01, 1'b0);
    run_op("edge nocarry", 16'h3100, 8'h00, 8'h12, 8'hFF, 1'b0);
    run_op("R6 wrap",      16'h4000, 8'h80, 8'hFF, 8'h90, 1'b0);
    run_op("R9 ptr wrap",  16'hFFFF, 8'h34, 8'h56, 8'h02, 1'b0);
    run_op("R7 busy start",16'h5000, 8'hC0, 8'h21, 8'h50, 1'b1);
    run_op("zero index",   16'h6000, 8'hFF, 8'h00, 8'h00, 1'b0);

    // R1: reset in the middle of a sequence
    @(negedge clk);
    start = 1'b1; oper_ptr = 16'h7000; index = 8'hFF;
    @(negedge clk);
    start = 1'b0;
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    cyc("R1 mid-op reset", 1'b0, 16'h0000, 1'b0, 8'h00, 1'b1);
    repeat (3) begin
      @(negedge clk);
      cyc("R1/R8 stays idle", 1'b0, 16'h0000, 1'b0, 8'h00, 1'b0);
    end
    run_op("after reset",  16'h7000, 8'h01, 8'h7F, 8'hFF, 1'b0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule